// File: doc/BRIEF.md
# Clamp-Relative Offset Measurement Window

This block decides, line by line, which pixel-clock cycles of ADC output an offset-correction loop should trust. The black-level clamp pulse arrives once per line. In clamp mode the capture window is the clamp pulse itself. In post-clamp mode the window waits a selectable 10 or 16 clocks after the clamp ends and then stays open for exactly six clocks. This lets the converter settle after the clamp switch releases before its codes are measured.

Every code taken inside the window is added to an accumulator. When the window closes, the block divides the sum by the number of codes taken and publishes the result with a one-cycle done pulse. The published value is held until the next measurement completes. The mode and delay selections are latched on the clamp's rising edge, so changing them mid-measurement has no effect on the measurement in progress. A clamp that rises again before a post-clamp measurement has finished cancels that measurement and starts a new one. The held selection resets to post-clamp mode with the 16-cycle delay.

Top module: `clamp_offset_window`

## Requirements
- R1: While reset is asserted, and afterwards until the first measurement completes, done_o is 0 and avg_o is 0. With clamp_i low after reset, win_o is 0.
- R2: In clamp mode (post_mode_i = 0 at the clamp rise), win_o is 1 in exactly the cycles where clamp_i is 1, and each of those cycles' code_i is captured.
- R3: In clamp mode, done_o pulses in the second cycle after the last clamp-high cycle, and avg_o then equals floor(sum of captured codes / number of captured codes).
- R4: In post-clamp mode (post_mode_i = 1 at the rise), the window opens D cycles after the first cycle in which clamp_i is low. D is 10 when long_delay_i = 0 and 16 when it is 1.
- R5: In post-clamp mode, the window lasts exactly 6 cycles. done_o pulses in the cycle after it, with avg_o = floor(sum of the 6 codes / 6).
- R6: done_o is high for one cycle per completed measurement, and avg_o changes only in that cycle.
- R7: A clamp rise while a post-clamp measurement is in its delay or window cancels it. No done pulse follows for it, avg_o is unchanged, and the new clamp starts a fresh measurement.
- R8: Changes on post_mode_i or long_delay_i after the clamp rise do not affect the current measurement. They apply from the next rise.
- R9: In clamp mode, only the first MAX_SPAN (default 64) codes of a clamp pulse enter the sum and the count.
- R10: In post-clamp mode, win_o stays 0 while clamp_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_i | input | 1 | Clamp pulse, active high |
| post_mode_i | input | 1 | 0: window follows clamp; 1: window after clamp |
| long_delay_i | input | 1 | Post-clamp delay select: 0 = 10 clocks, 1 = 16 clocks |
| code_i | input | CODE_W (10) | ADC output code |
| win_o | output | 1 | Capture window strobe; code_i is taken in this cycle |
| avg_o | output | CODE_W (10) | Average of the last completed window |
| done_o | output | 1 | One-cycle pulse when avg_o is refreshed |

## Verification
A clamp rise can land in the same cycle as another event, and these collisions are the cases most likely to be mishandled. In one test the clamp rises in the sixth and final cycle of a post-clamp window. The bench expects the sample to be dropped, no done pulse in the following cycle, and a fresh clamp-mode result two cycles after the new clamp falls. In another test a new clamp rises in exactly the cycle in which the previous clamp-mode done pulse is shown. The bench expects both averages, each formed only from its own pulse's codes.

// File: rtl/cow_pkg.sv
package cow_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SPAN,
        PH_HOLD,
        PH_WAIT,
        PH_MEAS
    } phase_t;

    typedef struct packed {
        logic clear;
        logic take;
        logic close;
    } acc_ctl_t;

    typedef struct packed {
        logic post;
        logic long_dly;
    } win_cfg_t;

    localparam win_cfg_t CFG_RESET = '{post: 1'b1, long_dly: 1'b1};

    function automatic int unsigned pick_delay(input logic long_dly,
                                               input int unsigned short_d,
                                               input int unsigned long_d);
        return long_dly ? long_d : short_d;
    endfunction

endpackage

// File: rtl/cow_clamp_track.sv
module cow_clamp_track
    import cow_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clamp_i,
    input  win_cfg_t cfg_live_i,
    output logic     rise_o,
    output win_cfg_t cfg_eff_o
);

    logic     clamp_q;
    win_cfg_t cfg_q;

    assign rise_o    = clamp_i & ~clamp_q;
    assign cfg_eff_o = rise_o ? cfg_live_i : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_q <= 1'b0;
            cfg_q   <= CFG_RESET;
        end else begin
            clamp_q <= clamp_i;
            if (rise_o) begin
                cfg_q <= cfg_live_i;
            end
        end
    end

    // R8: the held selection moves only on a clamp rise
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !rise_o |=> $stable(cfg_q));

endmodule

// File: rtl/cow_seq.sv
module cow_seq
    import cow_pkg::*;
#(
    parameter int unsigned SHORT_DLY = 10,
    parameter int unsigned LONG_DLY  = 16,
    parameter int unsigned MEAS_LEN  = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clamp_i,
    input  logic     rise_i,
    input  win_cfg_t cfg_eff_i,
    output logic     win_o,
    output acc_ctl_t ctl_o,
    output phase_t   phase_o
);

    localparam int unsigned DW = $clog2(LONG_DLY + 1);
    localparam int unsigned MW = $clog2(MEAS_LEN + 1);

    phase_t         phase_q, phase_d;
    logic [DW-1:0]  dcnt_q, dcnt_d;
    logic [MW-1:0]  mcnt_q, mcnt_d;
    logic [DW-1:0]  dly_lim;
    logic           meas_last;

    assign dly_lim   = DW'(pick_delay(cfg_eff_i.long_dly, SHORT_DLY, LONG_DLY) - 1);
    assign meas_last = (mcnt_q == MW'(MEAS_LEN - 1));

    assign win_o = (clamp_i & ~cfg_eff_i.post) | ((phase_q == PH_MEAS) & ~clamp_i);

    always_comb begin
        ctl_o.clear = rise_i;
        ctl_o.take  = win_o;
        ctl_o.close = ~clamp_i & (((phase_q == PH_SPAN)) |
                                  ((phase_q == PH_MEAS) & meas_last));
    end

    always_comb begin
        phase_d = phase_q;
        dcnt_d  = dcnt_q;
        mcnt_d  = mcnt_q;
        if (rise_i) begin
            phase_d = cfg_eff_i.post ? PH_HOLD : PH_SPAN;
            dcnt_d  = '0;
            mcnt_d  = '0;
        end else begin
            case (phase_q)
                PH_SPAN: begin
                    if (!clamp_i) phase_d = PH_IDLE;
                end
                PH_HOLD: begin
                    if (!clamp_i) begin
                        phase_d = PH_WAIT;
                        dcnt_d  = DW'(1);
                    end
                end
                PH_WAIT: begin
                    if (dcnt_q >= dly_lim) begin
                        phase_d = PH_MEAS;
                        mcnt_d  = '0;
                    end else begin
                        dcnt_d = dcnt_q + DW'(1);
                    end
                end
                PH_MEAS: begin
                    if (meas_last) phase_d = PH_IDLE;
                    else           mcnt_d  = mcnt_q + MW'(1);
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dcnt_q  <= '0;
            mcnt_q  <= '0;
        end else begin
            phase_q <= phase_d;
            dcnt_q  <= dcnt_d;
            mcnt_q  <= mcnt_d;
        end
    end

    assign phase_o = phase_q;

    // R4: the delay count never passes the selected delay
    assert_delay_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT) |-> (dcnt_q <= dly_lim));

    // R8: a rise always starts a fresh measurement phase
    assert_rise_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> (phase_q == PH_SPAN || phase_q == PH_HOLD));

    // R10: no capture while the clamp is high in post-clamp mode
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && clamp_i && !rise_i) |-> !win_o);

endmodule

// File: rtl/cow_accum.sv
module cow_accum
    import cow_pkg::*;
#(
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned MAX_SPAN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_ctl_t          ctl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] avg_o,
    output logic              done_o
);

    localparam int unsigned CW = $clog2(MAX_SPAN + 1);
    localparam int unsigned SW = CODE_W + CW;

    logic [SW-1:0]     sum_q, sum_base, sum_n, quot;
    logic [CW-1:0]     cnt_q, cnt_base, cnt_n;
    logic              take_ok;
    logic [CODE_W-1:0] avg_q;
    logic              done_q;
    logic              arm_q;

    assign sum_base = ctl_i.clear ? '0 : sum_q;
    assign cnt_base = ctl_i.clear ? '0 : cnt_q;
    assign take_ok  = ctl_i.take && (cnt_base < CW'(MAX_SPAN));
    assign sum_n    = sum_base + (take_ok ? SW'(code_i) : '0);
    assign cnt_n    = cnt_base + CW'(take_ok);
    assign quot     = (cnt_n == '0) ? '0 : (sum_n / SW'(cnt_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            avg_q  <= '0;
            done_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            sum_q  <= sum_n;
            cnt_q  <= cnt_n;
            done_q <= ctl_i.close && (cnt_n != '0);
            arm_q  <= 1'b1;
            if (ctl_i.close && (cnt_n != '0)) begin
                avg_q <= quot[CODE_W-1:0];
            end
        end
    end

    assign avg_o  = avg_q;
    assign done_o = done_q;

    // R9: the sample count never exceeds the clamp-span limit
    assert_cnt_cap_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_SPAN));

    // R6: the done strobe lasts a single cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: the published average moves only alongside done
    assert_avg_hold_R6: assert property (@(posedge clk) disable iff (rst || !arm_q)
        !done_o |-> $stable(avg_o));

    // R3: a result is only published after at least one capture
    assert_done_has_samples_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_q != '0));

endmodule

// File: rtl/clamp_offset_window.sv
module clamp_offset_window
    import cow_pkg::*;
#(
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned MAX_SPAN  = 64,
    parameter int unsigned SHORT_DLY = 10,
    parameter int unsigned LONG_DLY  = 16,
    parameter int unsigned MEAS_LEN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clamp_i,
    input  logic              post_mode_i,
    input  logic              long_delay_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              win_o,
    output logic [CODE_W-1:0] avg_o,
    output logic              done_o
);

    win_cfg_t cfg_live, cfg_eff;
    logic     rise;
    acc_ctl_t ctl;
    phase_t   phase;

    assign cfg_live = '{post: post_mode_i, long_dly: long_delay_i};

    cow_clamp_track u_track (
        .clk        (clk),
        .rst        (rst),
        .clamp_i    (clamp_i),
        .cfg_live_i (cfg_live),
        .rise_o     (rise),
        .cfg_eff_o  (cfg_eff)
    );

    cow_seq #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY),
        .MEAS_LEN  (MEAS_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clamp_i   (clamp_i),
        .rise_i    (rise),
        .cfg_eff_i (cfg_eff),
        .win_o     (win_o),
        .ctl_o     (ctl),
        .phase_o   (phase)
    );

    cow_accum #(
        .CODE_W   (CODE_W),
        .MAX_SPAN (MAX_SPAN)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .code_i (code_i),
        .avg_o  (avg_o),
        .done_o (done_o)
    );

    // R7: a clamp during the post-clamp delay or window suppresses the next done
    assert_abort_nodone_R7: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_WAIT || phase == PH_MEAS) && clamp_i) |=> !done_o);

endmodule

// File: tb/clamp_offset_window_tb.sv
module clamp_offset_window_tb;

    localparam int PERIOD = 10;
    localparam int NROWS  = 8;

    typedef struct packed {
        logic       m0;
        logic       d0;
        logic       m1;
        logic       d1;
        logic [7:0] len;
        logic [9:0] base;
        logic [3:0] inc;
    } row_t;

    // mode/delay at the rise, mode/delay after it, clamp length, code base, code step
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  10'd100,  4'd3},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  10'd513,  4'd0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd3,  10'd200,  4'd5},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'd2,  10'd1000, 4'd1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  10'd50,   4'd7},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd6,  10'd20,   4'd9},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd70, 10'd7,    4'd2},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd1,  10'd600,  4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clamp_i = 1'b0;
    logic       post_mode_i = 1'b1;
    logic       long_delay_i = 1'b1;
    logic [9:0] code_i = '0;
    logic       win_o;
    logic [9:0] avg_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    logic [9:0] held = '0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    clamp_offset_window u_dut (
        .clk          (clk),
        .rst          (rst),
        .clamp_i      (clamp_i),
        .post_mode_i  (post_mode_i),
        .long_delay_i (long_delay_i),
        .code_i       (code_i),
        .win_o        (win_o),
        .avg_o        (avg_o),
        .done_o       (done_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step(input logic cl, input logic m, input logic d, input logic [9:0] code,
                        input logic ew, input logic ed, input logic [9:0] ea,
                        input string tw, input string tr);
        @(negedge clk);
        clamp_i = cl; post_mode_i = m; long_delay_i = d; code_i = code;
        #1;
        chk({31'd0, win_o}, {31'd0, ew}, {tw, " win_o"});
        chk({31'd0, done_o}, {31'd0, ed}, {tr, " done_o"});
        chk({22'd0, avg_o}, {22'd0, ea}, {tr, " avg_o"});
    endtask

    task automatic run_row(input row_t r);
        int dly, tdone, nsamp, last;
        logic [31:0] sum;
        logic [9:0] navg;
        string tw, tr;
        logic changed;
        changed = (r.m0 != r.m1) || (r.d0 != r.d1);
        dly = r.d0 ? 16 : 10;
        sum = 0;
        nsamp = 0;
        if (!r.m0) begin
            for (int t = 0; t < int'(r.len) && t < 64; t++) begin
                sum += 32'((r.base + 10'(r.inc) * 10'(t)) & 10'h3FF);
                nsamp++;
            end
            tdone = int'(r.len) + 1;
        end else begin
            for (int t = int'(r.len) + dly; t < int'(r.len) + dly + 6; t++) begin
                sum += 32'((r.base + 10'(r.inc) * 10'(t)) & 10'h3FF);
                nsamp++;
            end
            tdone = int'(r.len) + dly + 6;
        end
        navg = 10'(sum / 32'(nsamp));
        last = tdone + 1;
        for (int t = 0; t <= last; t++) begin
            logic ew;
            logic [9:0] code;
            code = 10'(r.base + 10'(r.inc) * 10'(t));
            if (!r.m0) ew = (t < int'(r.len));
            else       ew = (t >= int'(r.len) + dly) && (t < int'(r.len) + dly + 6);
            if (changed) begin
                tw = "R8"; tr = "R8";
            end else if (!r.m0) begin
                tw = "R2"; tr = (r.len > 64) ? "R9" : "R3";
            end else begin
                tw = (t < int'(r.len)) ? "R10" : "R4"; tr = "R5";
            end
            if (t != tdone && t > 0) tr = changed ? "R8" : "R6";
            step(t < int'(r.len), (t == 0) ? r.m0 : r.m1, (t == 0) ? r.d0 : r.d1, code,
                 ew, t == tdone, (t >= tdone) ? navg : held, tw, tr);
        end
        held = navg;
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({31'd0, done_o}, 32'd0, "R1 done_o in reset");
        chk({22'd0, avg_o}, 32'd0, "R1 avg_o in reset");
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b1, 10'd77, 1'b0, 1'b0, 10'd0, "R1", "R1");
        step(1'b0, 1'b0, 1'b0, 10'd88, 1'b0, 1'b0, 10'd0, "R1", "R1");

        for (int i = 0; i < NROWS; i++) begin
            run_row(ROWS[i]);
        end

        // R7: clamp returns during the delay; result comes from the new clamp only
        for (int t = 0; t <= 10; t++) begin
            logic cl;
            cl = (t < 2) || (t >= 5 && t < 8);
            step(cl, (t < 5) ? 1'b1 : 1'b0, 1'b0, 10'(300 + t),
                 (t >= 5 && t < 8), t == 9, (t >= 9) ? 10'd306 : held, "R7", "R7");
        end
        held = 10'd306;

        // R7: clamp rises on the last window cycle; window sample dropped
        for (int t = 0; t <= 19; t++) begin
            step((t == 0) || (t == 16), (t < 16) ? 1'b1 : 1'b0, 1'b0, 10'(400 + t),
                 (t >= 11 && t <= 16), t == 18, (t >= 18) ? 10'd416 : held, "R7", "R7");
        end
        held = 10'd416;

        // R6/R3: new clamp rises in the cycle the previous done is shown
        for (int t = 0; t <= 7; t++) begin
            logic cl;
            logic [9:0] ea;
            cl = (t == 0) || (t == 1) || (t == 3) || (t == 4);
            ea = (t >= 6) ? 10'd507 : ((t >= 3) ? 10'd501 : held);
            step(cl, 1'b0, 1'b0, 10'(500 + 2 * t), cl, (t == 3) || (t == 6), ea, "R2", "R6");
        end
        held = 10'd507;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule